// File: doc/BRIEF.md
# Direct-Mapped Read Cache

This block sits between a processor read port and a slower main memory. A byte address arrives with a read request. The block splits the address into three fields: a tag, a line index and a byte offset. It looks up one line of a direct-mapped store and returns the addressed byte in the same cycle when the line holds that block. Only reads are handled.

On a miss the block raises a stall toward the requester. It asks memory for the whole line at the block-aligned address and waits for a single-beat response that carries every byte of the line. It writes the tag, data and valid flag of the indexed line. One cycle after the response it completes the original read, with the hit flag low to mark the miss. A refill always replaces what the indexed line held before.

The geometry is set by parameters: the address width, the number of index bits and the number of offset bits. The defaults give 16 lines of 4 bytes behind a 16-bit address.

Top module: `dmc_read_cache`

## Requirements
- R1: Address bits [OFF_W-1:0] are the byte offset, bits [OFF_W+IDX_W-1:OFF_W] are the line index, and the upper bits are the tag. A fetch drives `mem_addr_o` with the request address with its offset bits forced to zero.
- R2: After reset every line is invalid and `rd_stall_o`, `rd_valid_o` and `mem_req_o` are low, so the first read that lands on any line misses.
- R3: A read is a hit only when the indexed line is valid and its stored tag equals the address tag. A hit gives `rd_valid_o`=1, `rd_hit_o`=1 and the byte in the request cycle, and it raises no memory request.
- R4: A read that misses gives `rd_valid_o`=0 in its request cycle. From the next cycle `rd_stall_o` and `mem_req_o` are high, and `mem_addr_o` stays stable until the cycle in which `mem_rvalid_i` is sampled high.
- R5: On a refill, the cycle after `mem_rvalid_i` gives `rd_valid_o`=1 and `rd_hit_o`=0 with the requested byte. `rd_stall_o` drops one cycle later. Every byte of that block then hits.
- R6: Byte j of the memory line, `mem_rdata_i[8*j+7:8*j]`, is stored in byte j of the cache line, and the offset selects which byte is returned.
- R7: A miss overwrites the indexed line unconditionally, so alternating reads of two blocks that share an index miss on every access.
- R8: A request presented while `rd_stall_o` is high is ignored: it produces no response and leaves the pending fetch address unchanged.
- R9: `mem_rvalid_i` outside a pending fetch writes nothing; the line it could have filled still misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read request, accepted when stall is low |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| rd_stall_o | output | 1 | Miss in progress; requests are ignored |
| rd_valid_o | output | 1 | Read completes this cycle |
| rd_hit_o | output | 1 | Completed read was a hit |
| rd_data_o | output | 8 | Returned byte |
| mem_req_o | output | 1 | Line fetch pending |
| mem_addr_o | output | ADDR_W | Block-aligned fetch address |
| mem_rvalid_i | input | 1 | Memory line response valid |
| mem_rdata_i | input | 8<<OFF_W | Full line from memory |

## Verification
A stale valid flag or a corrupted tag shows up as a wrong hit flag on the very next read of that line. It is caught in the request cycle, because the bench predicts hit or miss from its own tag model. A fill into the wrong byte lane, or into the wrong line, surfaces as a wrong byte either in the completion cycle or on the first later hit to that block. A broken stall path appears at the ports as an extra completion, or as a fetch address that moves before the memory response.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } fill_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [OFF_W-1:0]  off_o
);
  assign off_o = addr_i[OFF_W-1:0];
  assign idx_o = addr_i[OFF_W+IDX_W-1:OFF_W];
  assign tag_o = addr_i[ADDR_W-1:OFF_W+IDX_W];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 10,
  parameter int LINE_W = 32,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [LINE_W-1:0] fill_line_i
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        valid_q <= '0;
    else if (fill_en_i) valid_q[fill_idx_i] <= 1'b1;
  end

  // tag and data need no reset: gated by valid
  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_q[fill_idx_i]  <= fill_tag_i;
      data_q[fill_idx_i] <= fill_line_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_line_o  = data_q[rd_idx_i];

  for (genvar g = 0; g < LINES; g++) begin : g_vchk
    assert_valid_only_on_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(valid_q[g]) |-> ($past(fill_en_i) && $past(fill_idx_i) == IDX_W'(g)));
  end
endmodule

// File: rtl/dmc_byte_sel.sv
module dmc_byte_sel #(
  parameter int OFF_W = 2,
  localparam int BYTES  = 1 << OFF_W,
  localparam int LINE_W = 8 * BYTES
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [7:0]        byte_o
);
  logic [7:0] lane [BYTES];
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane[g] = line_i[8*g +: 8];
  end
  assign byte_o = lane[off_i];
endmodule

// File: rtl/dmc_miss_ctrl.sv
module dmc_miss_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              mem_rvalid_i,
  output logic              stall_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              fill_en_o,
  output logic              resp_o,
  output logic [TAG_W-1:0]  sv_tag_o,
  output logic [IDX_W-1:0]  sv_idx_o,
  output logic [OFF_W-1:0]  sv_off_o
);
  fill_state_e state_q, state_d;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;
  logic [OFF_W-1:0] off_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (miss_i) state_d = ST_FETCH;
      ST_FETCH: if (mem_rvalid_i) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      idx_q   <= '0;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && miss_i) begin
        tag_q <= tag_i;
        idx_q <= idx_i;
        off_q <= off_i;
      end
    end
  end

  assign stall_o    = state_q != ST_IDLE;
  assign mem_req_o  = state_q == ST_FETCH;
  assign fill_en_o  = (state_q == ST_FETCH) && mem_rvalid_i;
  assign resp_o     = state_q == ST_RESP;
  assign mem_addr_o = {tag_q, idx_q, {OFF_W{1'b0}}};
  assign sv_tag_o   = tag_q;
  assign sv_idx_o   = idx_q;
  assign sv_off_o   = off_q;

  assert_fetch_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  assert_ignore_in_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !fill_en_o) |=> $stable(mem_addr_o));
endmodule

// File: rtl/dmc_read_cache.sv
module dmc_read_cache #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = 8 << OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_stall_o,
  output logic              rd_valid_o,
  output logic              rd_hit_o,
  output logic [7:0]        rd_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  logic [TAG_W-1:0]  req_tag, sv_tag, lk_tag;
  logic [IDX_W-1:0]  req_idx, sv_idx, lk_idx;
  logic [OFF_W-1:0]  req_off, sv_off, lk_off;
  logic              lk_valid, accept, hit, miss, fill_en, resp;
  logic [LINE_W-1:0] lk_line;

  dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .addr_i(rd_addr_i), .tag_o(req_tag), .idx_o(req_idx), .off_o(req_off)
  );

  // completion cycle reads the freshly filled line
  assign lk_idx = resp ? sv_idx : req_idx;
  assign lk_off = resp ? sv_off : req_off;

  dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_idx_i(lk_idx), .rd_valid_o(lk_valid), .rd_tag_o(lk_tag), .rd_line_o(lk_line),
    .fill_en_i(fill_en), .fill_idx_i(sv_idx), .fill_tag_i(sv_tag), .fill_line_i(mem_rdata_i)
  );

  dmc_byte_sel #(.OFF_W(OFF_W)) u_sel (
    .line_i(lk_line), .off_i(lk_off), .byte_o(rd_data_o)
  );

  assign accept = rd_req_i && !rd_stall_o;
  assign hit    = accept && lk_valid && (lk_tag == req_tag);
  assign miss   = accept && !hit;

  dmc_miss_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .miss_i(miss), .tag_i(req_tag), .idx_i(req_idx), .off_i(req_off),
    .mem_rvalid_i(mem_rvalid_i),
    .stall_o(rd_stall_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .fill_en_o(fill_en), .resp_o(resp),
    .sv_tag_o(sv_tag), .sv_idx_o(sv_idx), .sv_off_o(sv_off)
  );

  assign rd_valid_o = hit || resp;
  assign rd_hit_o   = hit;

  assert_block_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[OFF_W-1:0] == '0));
  assert_hit_no_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_hit_o) |-> !mem_req_o);
  assert_stall_after_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_stall_o) |-> $past(rd_req_i));
  assert_fill_resp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=> (rd_valid_o && !rd_hit_o && rd_stall_o));
  assert_spurious_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && mem_rvalid_i && !rd_req_i) |=> !rd_valid_o);
endmodule

// File: tb/tb_dmc_read_cache.sv
module tb_dmc_read_cache;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int OFF_W  = 2;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BYTES  = 1 << OFF_W;
  localparam int LINE_W = 8 * BYTES;
  localparam int LINES  = 1 << IDX_W;
  localparam int LAT    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_req = 1'b0, mem_rvalid = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [LINE_W-1:0] mem_rdata = '0;
  logic rd_stall, rd_valid, rd_hit, mem_req;
  logic [7:0] rd_data;
  logic [ADDR_W-1:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic             m_valid [LINES];
  logic [TAG_W-1:0] m_tag   [LINES];

  always #4 clk = ~clk;

  dmc_read_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_stall_o(rd_stall), .rd_valid_o(rd_valid), .rd_hit_o(rd_hit), .rd_data_o(rd_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [LINE_W-1:0] mem_line(input logic [ADDR_W-1:0] a);
    logic [LINE_W-1:0] l;
    for (int j = 0; j < BYTES; j++)
      l[8*j +: 8] = mem_byte({a[ADDR_W-1:OFF_W], OFF_W'(j)});
    return l;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // one read through the port; the model predicts hit or miss
  task automatic do_read(input logic [ADDR_W-1:0] a, input string rq,
                         input bit distract, output bit got_hit);
    logic [TAG_W-1:0] tg = a[ADDR_W-1:OFF_W+IDX_W];
    logic [IDX_W-1:0] ix = a[OFF_W+IDX_W-1:OFF_W];
    bit exp_hit = m_valid[ix] && (m_tag[ix] == tg);
    logic [ADDR_W-1:0] blk = {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    #1;
    got_hit = rd_valid && rd_hit;
    check(rd_hit == exp_hit, rq, "hit flag in request cycle", rd_hit, exp_hit);
    check(rd_valid == exp_hit, rq, "valid in request cycle", rd_valid, exp_hit);
    if (exp_hit) check(rd_data == mem_byte(a), rq, "hit data", rd_data, mem_byte(a));
    @(negedge clk);
    if (distract) begin
      rd_req = 1'b1; rd_addr = a ^ 16'h00C4;
    end else rd_req = 1'b0;
    if (!exp_hit) begin
      check(rd_stall && mem_req, "R4", "stall/req after miss", {rd_stall, mem_req}, 2'b11);
      check(mem_addr == blk, "R1", "fetch address", mem_addr, blk);
      for (int i = 0; i < LAT; i++) begin
        @(negedge clk);
        check(mem_req && mem_addr == blk && !rd_valid, distract ? "R8" : "R4",
              "hold during fetch", mem_addr, blk);
      end
      mem_rvalid = 1'b1; mem_rdata = mem_line(a);
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = ~mem_line(a);
      rd_req = 1'b0;
      check(rd_valid && !rd_hit, "R5", "miss completion flags", {rd_valid, rd_hit}, 2'b10);
      check(rd_data == mem_byte(a), "R6", "miss completion byte", rd_data, mem_byte(a));
      check(rd_stall && !mem_req, "R5", "stall in completion", {rd_stall, mem_req}, 2'b10);
      @(negedge clk);
      check(!rd_stall && !rd_valid, distract ? "R8" : "R5", "idle after miss",
            {rd_stall, rd_valid}, 2'b00);
      m_valid[ix] = 1'b1; m_tag[ix] = tg;
    end
  endtask

  task automatic t_reset;
    check(!rd_stall && !rd_valid && !mem_req, "R2", "outputs after reset",
          {rd_stall, rd_valid, mem_req}, 0);
  endtask

  task automatic t_cold_and_block(input logic [ADDR_W-1:0] a);
    bit h;
    do_read(a, "R2", 0, h);
    check(!h, "R2", "cold read misses", h, 0);
    for (int j = BYTES - 1; j >= 0; j--) begin
      do_read({a[ADDR_W-1:OFF_W], OFF_W'(j)}, "R6", 0, h);
      check(h, "R5", "block byte hits after fill", h, 1);
    end
  endtask

  task automatic t_tag_mismatch(input logic [ADDR_W-1:0] a);
    bit h;
    do_read(a ^ 16'h0400, "R3", 0, h);
    check(!h, "R3", "tag mismatch misses", h, 0);
  endtask

  task automatic t_thrash(input logic [ADDR_W-1:0] a);
    bit h;
    for (int i = 0; i < 6; i++) begin
      do_read((i % 2) ? (a ^ 16'h1000) : a, "R7", 0, h);
      check(!h, "R7", "aliasing read misses", h, 0);
    end
  endtask

  task automatic t_stall_ignore(input logic [ADDR_W-1:0] a);
    bit h;
    do_read(a, "R8", 1, h);
    check(!h, "R8", "miss with traffic during stall", h, 0);
    do_read(a ^ 16'h00C4, "R8", 0, h);
    check(!h, "R8", "ignored request left its line empty", h, 0);
  endtask

  task automatic t_spurious(input logic [ADDR_W-1:0] a);
    bit h;
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = mem_line(a);
    @(negedge clk);
    mem_rvalid = 1'b0;
    check(!rd_valid && !rd_stall, "R9", "no activity from stray response", rd_valid, 0);
    do_read(a, "R9", 0, h);
    check(!h, "R9", "stray response filled nothing", h, 0);
  endtask

  task automatic t_sweep;
    bit h;
    for (int i = 0; i < LINES; i++)
      do_read({10'h155, IDX_W'(i), OFF_W'(i)}, "R1", 0, h);
    for (int i = 0; i < LINES; i++) begin
      do_read({10'h155, IDX_W'(i), OFF_W'(i + 1)}, "R1", 0, h);
      check(h, "R1", "index sweep hits", h, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_and_block(16'h1234);
    t_tag_mismatch(16'h1234);
    t_thrash(16'h2A50);
    t_stall_ignore(16'h0A48);
    t_spurious(16'h7770);
    t_sweep();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule